// File: doc/BRIEF.md
# Programmable Three-Requester Priority Arbiter

This block gives one shared port to one of three requesters: a host processor, a DMA engine and an on-chip interconnect initiator. The ranking among them is a fixed-priority order, but that order can be changed while the chip runs. A 3-bit priority code, held in a small register inside the block, selects one of six permutations of the three requesters.

An arbitration decision is made only while no grant is active. The winner receives a one-hot grant, and the grant stays asserted until the shared port pulses its done input. After done, the block spends one idle cycle and then arbitrates again. If the priority code is rewritten while a transfer is in flight, the grant in progress is not affected. The new code applies from the next arbitration onward. The block does not carry the port datapath.

Top module: `tri_prio_arbiter`

## Requirements
- R1: After reset no grant is asserted, and the priority code register holds 000. With all three requesters active, the first grant goes to the host.
- R2: Bit positions are as follows: bit 0 is the host, bit 1 is the DMA engine and bit 2 is the interconnect initiator. This holds for the request vector and for the grant vector. Code 000 orders the requesters host, then DMA, then interconnect.
- R3: Code 001 orders host first, interconnect second and DMA last.
- R4: Code 010 puts DMA ahead of host, and host ahead of interconnect.
- R5: Code 011 puts interconnect ahead of host, and host ahead of DMA.
- R6: Codes 100 and 110 both order DMA, then interconnect, then host. Bit 1 of the code has no effect when bit 2 is set.
- R7: Codes 101 and 111 both order interconnect, then DMA, then host.
- R8: Once asserted, a grant keeps its value in every following cycle until done is sampled high. Changes on the request inputs do not alter it in that time.
- R9: A write to the priority code takes effect one cycle after the write strobe is sampled. A write made during an active grant does not change or drop that grant.
- R10: At most one grant bit is high at any time. No grant is issued in a cycle that follows an idle cycle without requests.
- R11: Done sampled high with a grant active clears the grant in the next cycle. Arbitration then resumes in the cycle after that. Done is ignored while no grant is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 3 | Requests: bit 0 host, bit 1 DMA, bit 2 interconnect |
| prio_we_i | input | 1 | Write strobe for the priority code register |
| prio_code_i | input | 3 | New priority code value |
| port_done_i | input | 1 | Shared port reports the granted transfer finished |
| gnt_o | output | 3 | One-hot grant, same bit order as req_i |

## Verification
The checker enforces several properties on every cycle. The grant is always one-hot or zero. A grant is stable until done arrives, and it clears in the cycle after done. A grant from idle goes to a requester that was actually asking, and nothing is granted after an idle cycle with no requests. Whether the correct requester won under each of the six orderings cannot be seen by those properties, and neither can the ignored middle code bit or the timing of a code write relative to a grant. Only the bench can show these, by comparing each grant against a rank model under directed and random request patterns.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
   localparam int unsigned TPA_NREQ  = 3;
   localparam int unsigned TPA_IDX_W = 2;
   localparam int unsigned TPA_CODE_W = 3;

   localparam logic [TPA_IDX_W-1:0] IDX_HOST = 2'd0;
   localparam logic [TPA_IDX_W-1:0] IDX_DMA  = 2'd1;
   localparam logic [TPA_IDX_W-1:0] IDX_FAB  = 2'd2;

   // slot 0 holds the highest-priority requester index
   typedef logic [TPA_NREQ-1:0][TPA_IDX_W-1:0] order_t;

   function automatic order_t decode_order(input logic [TPA_CODE_W-1:0] code);
      order_t o;
      if (code[2]) begin
         // bit 1 is a don't-care in this half of the code space
         if (code[0]) begin
            o[0] = IDX_FAB;  o[1] = IDX_DMA;  o[2] = IDX_HOST;
         end else begin
            o[0] = IDX_DMA;  o[1] = IDX_FAB;  o[2] = IDX_HOST;
         end
      end else begin
         unique case (code[1:0])
            2'b00:   begin o[0] = IDX_HOST; o[1] = IDX_DMA;  o[2] = IDX_FAB;  end
            2'b01:   begin o[0] = IDX_HOST; o[1] = IDX_FAB;  o[2] = IDX_DMA;  end
            2'b10:   begin o[0] = IDX_DMA;  o[1] = IDX_HOST; o[2] = IDX_FAB;  end
            default: begin o[0] = IDX_FAB;  o[1] = IDX_HOST; o[2] = IDX_DMA;  end
         endcase
      end
      return o;
   endfunction
endpackage

// File: rtl/tpa_cfg_reg.sv
module tpa_cfg_reg #(
   parameter int unsigned      WIDTH     = 3,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("tpa_cfg_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RESET_VAL;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/tpa_pick.sv
module tpa_pick #(
   parameter int unsigned NREQ  = 3,
   parameter int unsigned IDX_W = 2
) (
   input  logic [NREQ-1:0][IDX_W-1:0] order,
   input  logic [NREQ-1:0]            req,
   output logic [NREQ-1:0]            pick
);
   localparam int unsigned MAX_IDX = (1 << IDX_W) - 1;

   if (NREQ < 2 || NREQ - 1 > MAX_IDX) begin : g_bad_cfg
      $error("tpa_pick: IDX_W too narrow for NREQ");
   end

   logic [NREQ-1:0] slot_req;
   logic [NREQ-1:0] slot_win;

   for (genvar k = 0; k < NREQ; k++) begin : g_slot
      assign slot_req[k] = req[order[k]];
      if (k == 0) begin : g_top
         assign slot_win[k] = slot_req[k];
      end else begin : g_lower
         assign slot_win[k] = slot_req[k] & ~(|slot_req[k-1:0]);
      end
   end

   always_comb begin
      pick = '0;
      for (int k = 0; k < NREQ; k++) begin
         if (slot_win[k]) pick[order[k]] = 1'b1;
      end
   end
endmodule

// File: rtl/tpa_grant_fsm.sv
module tpa_grant_fsm #(
   parameter int unsigned NREQ = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] pick,
   input  logic            done,
   output logic [NREQ-1:0] gnt
);
   logic owned;
   assign owned = |gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gnt <= '0;
      else if (!owned)   gnt <= pick;
      else if (done)     gnt <= '0;
   end
endmodule

// File: rtl/tri_prio_arbiter.sv
module tri_prio_arbiter
   import tpa_pkg::*;
#(
   parameter int unsigned           NREQ       = TPA_NREQ,
   parameter int unsigned           CODE_W     = TPA_CODE_W,
   parameter logic [CODE_W-1:0]     RESET_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREQ-1:0]   req_i,
   input  logic              prio_we_i,
   input  logic [CODE_W-1:0] prio_code_i,
   input  logic              port_done_i,
   output logic [NREQ-1:0]   gnt_o
);
   if (NREQ != TPA_NREQ || CODE_W != TPA_CODE_W) begin : g_bad_cfg
      $error("tri_prio_arbiter: ordering table is defined for three requesters and a 3-bit code");
   end

   logic [CODE_W-1:0] code_q;
   order_t            order;
   logic [NREQ-1:0]   pick;

   tpa_cfg_reg #(
      .WIDTH     (CODE_W),
      .RESET_VAL (RESET_CODE)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (prio_we_i),
      .wdata (prio_code_i),
      .q     (code_q)
   );

   assign order = decode_order(code_q);

   tpa_pick #(
      .NREQ  (NREQ),
      .IDX_W (TPA_IDX_W)
   ) u_pick (
      .order (order),
      .req   (req_i),
      .pick  (pick)
   );

   tpa_grant_fsm #(
      .NREQ (NREQ)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .pick  (pick),
      .done  (port_done_i),
      .gnt   (gnt_o)
   );
endmodule

// File: rtl/tpa_checker.sv
module tpa_checker #(
   parameter int unsigned NREQ = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NREQ-1:0] req,
   input logic            done,
   input logic [NREQ-1:0] gnt
);
   a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   a_r10_no_req_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req == '0) |=> (gnt == '0));

   a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && !done) |=> (gnt == $past(gnt)));

   a_r11_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && done) |=> (gnt == '0));

   a_r10_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req != '0) |=> ((gnt & $past(req)) != '0));
endmodule

bind tri_prio_arbiter tpa_checker #(.NREQ(NREQ)) u_tpa_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .req   (req_i),
   .done  (port_done_i),
   .gnt   (gnt_o)
);

// File: tb/tb_tri_prio_arbiter.sv
module tb_tri_prio_arbiter;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] req;
   logic       we;
   logic [2:0] wd;
   logic       done;
   logic [2:0] gnt;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [2:0] m_code;
   logic [2:0] m_gnt;

   always #10 clk = ~clk;

   tri_prio_arbiter dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .prio_we_i(we),
      .prio_code_i(wd), .port_done_i(done), .gnt_o(gnt)
   );

   // rank of each requester (1 = highest) for a code: host, dma, fab
   function automatic int rank_of(input logic [2:0] code, input int who);
      int r [3];
      case (code)
         3'b000:          r = '{1, 2, 3};
         3'b001:          r = '{1, 3, 2};
         3'b010:          r = '{2, 1, 3};
         3'b011:          r = '{2, 3, 1};
         3'b100, 3'b110:  r = '{3, 1, 2};
         default:         r = '{3, 2, 1};
      endcase
      return r[who];
   endfunction

   function automatic logic [2:0] model_pick(input logic [2:0] code, input logic [2:0] r);
      int best = 4;
      logic [2:0] g = 3'b000;
      for (int i = 0; i < 3; i++) begin
         if (r[i] && rank_of(code, i) < best) begin
            best = rank_of(code, i);
            g = 3'b001 << i;
         end
      end
      return g;
   endfunction

   function automatic string code_tag(input logic [2:0] c);
      if (c[2]) return c[0] ? "R7" : "R6";
      case (c[1:0])
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: gnt actual %b expected %b", tag, act, exp);
      end
   endtask

   // drive inputs, advance one edge, compare against the model
   task automatic step(input logic [2:0] r, input logic d, input logic w, input logic [2:0] c);
      logic [2:0] nxt;
      string tag;
      req = r; done = d; we = w; wd = c;
      if (m_gnt == 3'b000) begin
         nxt = model_pick(m_code, r);
         tag = (r == 3'b000) ? "R10" : code_tag(m_code);
      end else if (d) begin
         nxt = 3'b000;
         tag = "R11";
      end else begin
         nxt = m_gnt;
         tag = w ? "R9" : "R8";
      end
      @(posedge clk);
      #2;
      if (w) m_code = c;
      m_gnt = nxt;
      check(tag, gnt, m_gnt);
   endtask

   // grant all three at once under a code and release
   task automatic try_code(input logic [2:0] c);
      step(3'b000, 1'b0, 1'b1, c);
      step(3'b111, 1'b0, 1'b0, 3'b000);
      step(3'b111, 1'b1, 1'b0, 3'b000);
      step(3'b000, 1'b0, 1'b0, 3'b000);
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_A3B1));
      req = 0; we = 0; wd = 0; done = 0;
      rst_n = 1'b0;
      m_code = 3'b000;
      m_gnt  = 3'b000;
      repeat (3) @(posedge clk);
      #2;
      check("R1", gnt, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset code favours the host
      step(3'b111, 1'b0, 1'b0, 3'b000);
      check("R1", gnt, 3'b001);
      step(3'b111, 1'b1, 1'b0, 3'b000);
      step(3'b000, 1'b0, 1'b0, 3'b000);

      // R2..R7 each ordering, including both middle-bit values for R6 and R7
      for (int c = 0; c < 8; c++) try_code(c[2:0]);

      // R10: done with no grant and no requests changes nothing
      step(3'b000, 1'b1, 1'b0, 3'b000);
      step(3'b000, 1'b0, 1'b0, 3'b000);

      // R8: request churn during a grant
      step(3'b010, 1'b0, 1'b1, 3'b000);
      step(3'b001, 1'b0, 1'b0, 3'b000);
      step(3'b010, 1'b0, 1'b0, 3'b000);
      step(3'b100, 1'b0, 1'b0, 3'b000);
      step(3'b000, 1'b1, 1'b0, 3'b000);

      // R9: rewrite code mid-grant, then the new order applies
      step(3'b111, 1'b0, 1'b0, 3'b000);
      step(3'b111, 1'b0, 1'b1, 3'b101);
      check("R9", gnt, 3'b001);
      step(3'b111, 1'b1, 1'b0, 3'b000);
      step(3'b111, 1'b0, 1'b0, 3'b000);
      check("R9", gnt, 3'b100);
      step(3'b011, 1'b1, 1'b0, 3'b000);
      // R11: idle cycle after done, then DMA wins under 101 without fab
      step(3'b011, 1'b0, 1'b0, 3'b000);
      check("R7", gnt, 3'b010);
      step(3'b000, 1'b1, 1'b0, 3'b000);

      // R9: write in the same idle cycle as a request uses the old code
      step(3'b111, 1'b0, 1'b1, 3'b010);
      check("R9", gnt, 3'b100);
      step(3'b111, 1'b1, 1'b0, 3'b000);
      step(3'b111, 1'b0, 1'b0, 3'b000);
      check("R4", gnt, 3'b010);
      step(3'b000, 1'b1, 1'b0, 3'b000);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] r;
         logic d, w;
         logic [2:0] c;
         r = 3'($urandom_range(0, 7));
         d = ($urandom_range(0, 2) == 0);
         w = ($urandom_range(0, 7) == 0);
         c = 3'($urandom_range(0, 7));
         step(r, d, w, c);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule